// File: doc/BRIEF.md
# Multi-channel clock enable generator

This block lives in the fast core clock domain and produces single-cycle enable pulses instead of divided clocks. It generates one shared enable from a common divisor and three channel enables, named RW, I and P. Each channel owns a ratio down-counter. A per-channel source bit selects whether the channel output comes from that counter or repeats the shared enable. Logic clocked by the core clock uses these pulses to advance slower bus-side state.

All settings sit in one configuration word. The word holds the shared divisor, the three channel ratios and the three source bits. While reset is applied, the word is taken from an init bus. Afterwards a single write strobe replaces the whole word. A new ratio is used only at that divider's next terminal count, so a period that is already running is never cut short. A new source bit is used only at a shared-enable boundary. All counters restart together when reset is released, so channels set to equal ratios stay in phase.

Top module: `clk_en_gen`

## Requirements
- R1: While reset is active, and for two clock edges after `rst_n` rises (synchronised release), all four enables are 0. In the cycle after the second edge, all four enables are 1 together.
- R2: For a ratio N in 2..15, a channel whose source bit is 1 pulses once every N core cycles, and the pulse is one cycle wide.
- R3: A ratio of 0 or 1 holds the enable at 1 on every cycle.
- R4: A ratio written while a period is running does not change that period. It is first used after the next pulse. Example: ratio 6, and 3 is written two cycles after a pulse; the next gaps are 6, then 3.
- R5: A channel whose source bit is 0 equals `en_shared_o` on every cycle. `en_shared_o` pulses once every D cycles for a shared divisor D, and 0 or 1 gives an enable that is always 1.
- R6: A source bit change takes effect only in the cycle after the next shared pulse. Up to and including that pulse, the channel still follows the shared enable.
- R7: Configuration word layout (width 4·DIV_W+3, DIV_W=4 gives 19 bits): bits [3:0] shared divisor, [7:4] RW ratio, [11:8] I ratio, [15:12] P ratio, bit 16 RW source, bit 17 I source, bit 18 P source. The word is loaded from `init_cfg` on every clock while reset is active. A cycle with `wr_en`=1 replaces the whole word with `wr_data`, which uses the same layout.
- R8: Channels that have equal ratios and source 1 pulse in the same cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| init_cfg | input | 4·DIV_W+3 | Configuration word loaded during reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 4·DIV_W+3 | New configuration word |
| en_shared_o | output | 1 | Shared internal enable |
| en_rw_o | output | 1 | RW channel enable |
| en_i_o | output | 1 | I channel enable |
| en_p_o | output | 1 | P channel enable |

## Verification
The bench builds the block with the default DIV_W of 4. This puts the whole ratio range within reach: the degenerate values 0 and 1, small ratios, and the maximum of 15. A vector table sweeps ratios across all three channels and compares the measured pulse spacing. Directed tests cover the reset release and phase alignment, the source mux on the shared enable, a mid-period ratio change, a source switch timed against the shared boundary, and a second reset that takes a different init word.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_RW  = 0;
  localparam int unsigned CH_I   = 1;
  localparam int unsigned CH_P   = 2;

  // Divider index 0 is the shared divisor, 1..NUM_CH are the channels.
  function automatic int unsigned div_lsb(input int unsigned idx, input int unsigned w);
    return idx * w;
  endfunction

  function automatic int unsigned src_lsb(input int unsigned w);
    return (NUM_CH + 1) * w;
  endfunction
endpackage

// File: rtl/clk_en_rst_sync.sv
module clk_en_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/clk_en_cfg.sv
module clk_en_cfg import clk_en_pkg::*; #(
  parameter int unsigned DIV_W = 4,
  localparam int unsigned CFG_W = (NUM_CH + 1) * DIV_W + NUM_CH
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic [CFG_W-1:0]  init_cfg,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              shared_pulse,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [NUM_CH-1:0] sel_q
);
  localparam int unsigned SRC_LSB = src_lsb(DIV_W);

  logic [CFG_W-1:0]  cfg_d;
  logic [NUM_CH-1:0] sel_d;

  always_comb begin
    cfg_d = cfg_q;
    sel_d = sel_q;
    if (!rst_q_n) begin
      cfg_d = init_cfg;
      sel_d = init_cfg[SRC_LSB +: NUM_CH];
    end else begin
      if (wr_en)        cfg_d = wr_data;
      if (shared_pulse) sel_d = cfg_q[SRC_LSB +: NUM_CH];
    end
  end

  // Loaded synchronously from init_cfg while reset is held.
  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
    sel_q <= sel_d;
  end

  // R6: the source selection moves only on a shared boundary
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !shared_pulse |=> $stable(sel_q));
endmodule

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [DIV_W-1:0] ratio,
  output logic             en_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] reload;
  logic             at_term;

  always_comb begin
    at_term = (cnt_q == '0);
    reload  = (ratio <= DIV_W'(1)) ? '0 : ratio - DIV_W'(1);
    cnt_d   = at_term ? reload : cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign en_o = at_term & rst_q_n;

  // R2: a pulse with ratio above one is followed by a quiet cycle
  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_o && ratio > DIV_W'(1)) |=> !en_o);
  // R3: ratio zero or one keeps the enable high
  p_full_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_o && ratio <= DIV_W'(1)) |=> en_o);
  // R4: between pulses the count only steps down, never reloads
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_o |=> (cnt_q == $past(cnt_q) - DIV_W'(1)));
endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen import clk_en_pkg::*; #(
  parameter int unsigned DIV_W = 4,
  localparam int unsigned CFG_W = (NUM_CH + 1) * DIV_W + NUM_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] init_cfg,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic             en_shared_o,
  output logic             en_rw_o,
  output logic             en_i_o,
  output logic             en_p_o
);
  logic              rst_q_n;
  logic [CFG_W-1:0]  cfg_q;
  logic [NUM_CH-1:0] sel_q;
  logic [NUM_CH:0]   en_div;
  logic [NUM_CH-1:0] en_ch;

  clk_en_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  clk_en_cfg #(.DIV_W(DIV_W)) i_cfg (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .init_cfg     (init_cfg),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .shared_pulse (en_div[0]),
    .cfg_q        (cfg_q),
    .sel_q        (sel_q)
  );

  for (genvar g = 0; g <= NUM_CH; g++) begin : g_div
    clk_en_div #(.DIV_W(DIV_W)) i_div (
      .clk     (clk),
      .rst_q_n (rst_q_n),
      .ratio   (cfg_q[div_lsb(g, DIV_W) +: DIV_W]),
      .en_o    (en_div[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mux
    assign en_ch[c] = sel_q[c] ? en_div[c + 1] : en_div[0];
  end

  assign en_shared_o = en_div[0];
  assign en_rw_o     = en_ch[CH_RW];
  assign en_i_o      = en_ch[CH_I];
  assign en_p_o      = en_ch[CH_P];

  // R1: no enable leaves the block while the synchronised reset is held
  p_quiet_r1: assert property (@(posedge clk)
    !rst_q_n |-> !(en_shared_o || en_rw_o || en_i_o || en_p_o));
endmodule

// File: tb/test_clk_en_gen.sv
module test_clk_en_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 4;
  localparam int CFG_W = 4 * DIV_W + 3;

  // {ratio, expected gap}
  localparam logic [7:0] VEC [0:5] = '{8'h22, 8'h33, 8'h77, 8'hff, 8'h01, 8'h11};

  logic clk = 1'b0;
  logic rst_n;
  logic [CFG_W-1:0] init_cfg;
  logic wr_en;
  logic [CFG_W-1:0] wr_data;
  logic en_shared_o, en_rw_o, en_i_o, en_p_o;

  int n_cmp = 0;
  int n_bad = 0;

  clk_en_gen #(.DIV_W(DIV_W)) i_clk_en_gen (
    .clk(clk), .rst_n(rst_n), .init_cfg(init_cfg), .wr_en(wr_en),
    .wr_data(wr_data), .en_shared_o(en_shared_o), .en_rw_o(en_rw_o),
    .en_i_o(en_i_o), .en_p_o(en_p_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CFG_W-1:0] mk(input int sh, input int rw, input int ri,
                                          input int rp, input logic [2:0] src);
    return {src, 4'(rp), 4'(ri), 4'(rw), 4'(sh)};
  endfunction

  function automatic logic sig(input int ch);
    case (ch)
      0:       return en_shared_o;
      1:       return en_rw_o;
      2:       return en_i_o;
      default: return en_p_o;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [CFG_W-1:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gap(input int ch, output int g);
    int lim = 0;
    do begin @(negedge clk); lim++; end while (!sig(ch) && lim < 100);
    g = 0;
    do begin @(negedge clk); g++; end while (!sig(ch) && g < 100);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int g, k, cnt, bad;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    init_cfg = mk(4, 3, 3, 5, 3'b111);
    repeat (5) @(negedge clk);
    check(!(en_shared_o || en_rw_o || en_i_o || en_p_o), "R1 quiet in reset", 1, 0);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!en_rw_o && k < 20);
    check(k == 2, "R1 first pulse delay", k, 2);
    check(en_shared_o && en_i_o && en_p_o, "R1/R8 aligned first pulse", 0, 1);
    bad = 0;
    for (int n = 0; n < 30; n++) begin @(negedge clk); if (en_rw_o != en_i_o) bad++; end
    check(bad == 0, "R8 equal ratios in phase", bad, 0);
    gap(1, g); check(g == 3, "R7 init RW ratio", g, 3);
    gap(3, g); check(g == 5, "R7 init P ratio", g, 5);
    gap(0, g); check(g == 4, "R7 init shared divisor", g, 4);

    // ratio sweep (R2 / R3 / R7 write)
    for (int v = 0; v < 6; v++) begin
      int r, e;
      r = int'(VEC[v][7:4]);
      e = int'(VEC[v][3:0]);
      wr(mk(4, r, r, r, 3'b111));
      gap(1, g); gap(1, g);
      for (int ch = 1; ch <= 3; ch++) begin
        gap(ch, g);
        check(g == e, (r <= 1) ? "R3 ratio 0/1 always on" : "R2 pulse spacing", g, e);
      end
    end

    // R4 mid-period ratio change
    wr(mk(4, 6, 6, 6, 3'b111));
    gap(1, g); gap(1, g);
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 2) begin wr_en = 1'b1; wr_data = mk(4, 3, 6, 6, 3'b111); end
      if (k == 3) wr_en = 1'b0;
    end while (!en_rw_o && k < 100);
    check(k == 6, "R4 running period kept", k, 6);
    gap(1, g); check(g == 3, "R4 new ratio after pulse", g, 3);

    // R5 source 0 follows shared enable
    wr(mk(5, 3, 2, 4, 3'b000));
    repeat (20) @(negedge clk);
    bad = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (en_rw_o != en_shared_o || en_i_o != en_shared_o || en_p_o != en_shared_o) bad++;
    end
    check(bad == 0, "R5 channels equal shared", bad, 0);
    gap(0, g); check(g == 5, "R5 shared spacing", g, 5);

    // R6 source switch at shared boundary
    wr(mk(7, 2, 2, 2, 3'b000));
    repeat (20) @(negedge clk);
    k = 0;
    do begin @(negedge clk); k++; end while (!en_shared_o && k < 100);
    cnt = 0;
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (n == 1) begin wr_en = 1'b1; wr_data = mk(7, 2, 2, 2, 3'b001); end
      if (n == 2) wr_en = 1'b0;
      if (en_rw_o) cnt++;
    end
    check(en_shared_o, "R5 shared pulse at 7", 0, 1);
    check(cnt == 1, "R6 old source kept until boundary", cnt, 1);
    gap(1, g); check(g == 2, "R6 own divider after boundary", g, 2);
    gap(2, g); check(g == 7, "R6 other channel still shared", g, 7);

    // R7 second reset picks up a new init word
    rst_n = 1'b0;
    init_cfg = mk(2, 4, 6, 1, 3'b010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gap(1, g); check(g == 2, "R7 RW source 0 from init", g, 2);
    gap(2, g); check(g == 6, "R7 I ratio from init", g, 6);
    bad = 0;
    for (int n = 0; n < 20; n++) begin @(negedge clk); if (en_p_o != en_shared_o) bad++; end
    check(bad == 0, "R7 P source 0 from init", bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule